// File: doc/BRIEF.md
# Five-Level Vectored Interrupt Controller

The block takes five hardware interrupt request lines and turns them into a single pending indication for a processor core. That indication carries either a fixed 16-bit service address, or a flag telling the core that an external device must supply the address. Every request line first passes through a two-flop synchroniser.

The lines use three kinds of sensing:
- The non-maskable line is armed by a rising edge. It stays armed only while the input remains high.
- The maskable edge line is captured in a sticky latch. Software can clear that latch.
- The two vectored level lines and the general line follow their inputs.

Software writes a three-bit mask and sets or clears a global enable. The core pulses `accept` when it takes the presented request. Taking a request has three effects: it clears the global enable, it empties the latch of the line that was taken, and, for the general line, it produces a one-cycle acknowledge.

Top module: `irq5_ctrl`

## Requirements
- R1: The lines `irq_raw[2]`, `irq_raw[1]` and `irq_raw[0]` are level sensitive. Once enabled and unmasked, a line raises `irq_pend` two clock edges after its input rises. The pending indication drops again after the input falls, with nothing held.
- R2: Among the eligible requests, the highest index of `irq_raw` wins, from bit 4 down to bit 0. The address `irq_vec` is 0x0024 for bit 4, 0x003C for bit 3, 0x0034 for bit 2 and 0x002C for bit 1.
- R3: Line `irq_raw[4]` ignores the masks and the global enable. A low-to-high transition arms it. It stays armed only while the input stays high, and an input that is held high does not arm it again.
- R4: A rising edge on `irq_raw[3]` sets a latch, even while the line is masked. The latch holds after the input falls. A mask write with `mask_clr_edge`=1 clears it, and a mask write with `mask_clr_edge`=0 leaves it unchanged.
- R5: Mask bits take effect on a write with `mask_wr`=1. `mask_din[2]` masks line 3, `mask_din[1]` masks line 2 and `mask_din[0]` masks line 1, where 1 means masked. Line 0 has no mask bit.
- R6: A pulse on `ien_set` sets the global enable and a pulse on `ien_clr` clears it; when both arrive in the same cycle, the enable is cleared. The enable gates lines 3 to 0.
- R7: After reset the global enable is 0, all three mask bits are 1 and both latches are empty. `irq_pend`, `irq_vec`, `vec_ext` and `ext_ack` are all 0.
- R8: `accept` while `irq_pend`=1 clears the global enable. It also clears the latch of line 4 or line 3 when that line was the one taken. `accept` while nothing is pending changes nothing.
- R9: When line 0 is selected, `vec_ext`=1 and `irq_vec`=0. Taking it raises `ext_ack` for exactly the one cycle after `accept`.
- R10: With nothing pending, `irq_vec` is 0 and `vec_ext` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 5 | Asynchronous request lines, bit 4 highest priority |
| mask_wr | input | 1 | Load `mask_din` into the mask register |
| mask_din | input | 3 | New mask bits for lines 3, 2, 1 (1 = masked) |
| mask_clr_edge | input | 1 | With `mask_wr`, empty the line-3 edge latch |
| ien_set | input | 1 | Set global enable |
| ien_clr | input | 1 | Clear global enable (wins over set) |
| accept | input | 1 | Core takes the presented request |
| irq_pend | output | 1 | An eligible request is pending |
| irq_vec | output | VEC_W | Service address of the selected line |
| vec_ext | output | 1 | Selected line needs an externally supplied address |
| ext_ack | output | 1 | One-cycle acknowledge after the general line is taken |

## Verification
The hardest situation to reach is an edge on line 3 that arrives while the line is masked, and then outlives its own input. The stimulus drives a full high-then-low pulse under the mask. It then unmasks the line with a write that does not clear the latch, and expects the vector to appear straight away. The non-maskable line is exercised the same way: the input is held high across an accept, to show that the line does not arm again without a fresh edge.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
  localparam int LINES    = 5;
  localparam int MASK_W   = 3;
  localparam int IDX_NMI  = 4;
  localparam int IDX_EDGE = 3;
  localparam int IDX_LA   = 2;
  localparam int IDX_LB   = 1;
  localparam int IDX_GEN  = 0;

  // fixed service address per line; the general line gets none
  function automatic logic [15:0] line_vector(input int idx);
    case (idx)
      IDX_NMI:  return 16'h0024;
      IDX_EDGE: return 16'h003C;
      IDX_LA:   return 16'h0034;
      IDX_LB:   return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/irq5_sync.sv
module irq5_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq5_edge_cap.sv
module irq5_edge_cap #(
  parameter bit HOLD = 1'b0   // 1: request also needs the level to stay high
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic req
);
  logic prev_q, cap_q, cap_n, rise;

  assign rise = lvl & ~prev_q;

  generate
    if (HOLD) begin : g_hold
      always_comb cap_n = clr ? 1'b0 : ((cap_q | rise) & lvl);
    end else begin : g_sticky
      always_comb cap_n = clr ? 1'b0 : (cap_q | rise);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      cap_q  <= cap_n;
    end
  end

  assign req = cap_q;
endmodule

// File: rtl/irq5_prio.sv
module irq5_prio
  import irq5_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic [LINES-1:0] cand,
  output logic             any,
  output logic [LINES-1:0] sel,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    vec = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (cand[i] && !any) begin
        any    = 1'b1;
        sel[i] = 1'b1;
        vec    = VEC_W'(line_vector(i));
      end
    end
  end
endmodule

// File: rtl/irq5_ctrl.sv
module irq5_ctrl
  import irq5_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_raw,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_din,
  input  logic              mask_clr_edge,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              accept,
  output logic              irq_pend,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              vec_ext,
  output logic              ext_ack
);
  logic [LINES-1:0]  sync_lv;
  logic [LINES-1:0]  cand, sel;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic              ien_q, ien_n, ack_q, ack_n;
  logic              nmi_req, edge_req, nmi_clr, edge_clr, any, take;

  irq5_sync #(.W(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(irq_raw), .q(sync_lv)
  );

  irq5_edge_cap #(.HOLD(1'b1)) nmi_cap_i (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lv[IDX_NMI]), .clr(nmi_clr), .req(nmi_req)
  );

  irq5_edge_cap #(.HOLD(1'b0)) edge_cap_i (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lv[IDX_EDGE]), .clr(edge_clr), .req(edge_req)
  );

  always_comb begin
    cand           = '0;
    cand[IDX_NMI]  = nmi_req;
    cand[IDX_EDGE] = ien_q & ~mask_q[2] & edge_req;
    cand[IDX_LA]   = ien_q & ~mask_q[1] & sync_lv[IDX_LA];
    cand[IDX_LB]   = ien_q & ~mask_q[0] & sync_lv[IDX_LB];
    cand[IDX_GEN]  = ien_q & sync_lv[IDX_GEN];
  end

  irq5_prio #(.VEC_W(VEC_W)) prio_i (
    .cand(cand), .any(any), .sel(sel), .vec(irq_vec)
  );

  assign take     = accept & any;
  assign nmi_clr  = take & sel[IDX_NMI];
  assign edge_clr = (mask_wr & mask_clr_edge) | (take & sel[IDX_EDGE]);

  // next-state
  always_comb begin
    ien_n = ien_q;
    if (ien_set) ien_n = 1'b1;
    if (ien_clr || take) ien_n = 1'b0;
    mask_n = mask_wr ? mask_din : mask_q;
    ack_n  = take & sel[IDX_GEN];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
      ack_q  <= 1'b0;
    end else begin
      ien_q  <= ien_n;
      mask_q <= mask_n;
      ack_q  <= ack_n;
    end
  end

  assign irq_pend = any;
  assign vec_ext  = sel[IDX_GEN];
  assign ext_ack  = ack_q;
endmodule

// File: rtl/irq5_ctrl_chk.sv
module irq5_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             irq_pend,
  input logic [VEC_W-1:0] irq_vec,
  input logic             vec_ext,
  input logic             ext_ack,
  input logic             ien_q,
  input logic             nmi_req,
  input logic [4:0]       sel
);
  a_r10_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |-> (irq_vec == '0 && !vec_ext));

  a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (irq_pend && irq_vec == VEC_W'(16'h0024)));

  a_r8_accept_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && irq_pend) |=> !ien_q);

  a_r6_disabled_only_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !nmi_req) |-> !irq_pend);

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> !ext_ack);

  a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> $past(accept && vec_ext));

  a_r2_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

bind irq5_ctrl irq5_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .irq_pend(irq_pend),
  .irq_vec(irq_vec), .vec_ext(vec_ext), .ext_ack(ext_ack),
  .ien_q(ien_q), .nmi_req(nmi_req), .sel(sel)
);

// File: tb/irq5_ctrl_tb.sv
module irq5_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTBL = 12;
  // {raw[4:0], mask[2:0], ien, pend, ext, vec[15:0]}
  localparam logic [26:0] TBL [NTBL] = '{
    {5'b00001, 3'b000, 1'b1, 1'b1, 1'b1, 16'h0000},
    {5'b00011, 3'b000, 1'b1, 1'b1, 1'b0, 16'h002C},
    {5'b00111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0034},
    {5'b01111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h003C},
    {5'b11111, 3'b000, 1'b1, 1'b1, 1'b0, 16'h0024},
    {5'b10000, 3'b111, 1'b0, 1'b1, 1'b0, 16'h0024},
    {5'b00111, 3'b111, 1'b1, 1'b1, 1'b1, 16'h0000},
    {5'b00111, 3'b010, 1'b1, 1'b1, 1'b0, 16'h002C},
    {5'b00110, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0000},
    {5'b01000, 3'b100, 1'b1, 1'b0, 1'b0, 16'h0000},
    {5'b01000, 3'b011, 1'b1, 1'b1, 1'b0, 16'h003C},
    {5'b00001, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  irq_raw;
  logic        mask_wr, mask_clr_edge, ien_set, ien_clr, accept;
  logic [2:0]  mask_din;
  logic        irq_pend, vec_ext, ext_ack;
  logic [15:0] irq_vec;
  int          n_checks = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq5_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .mask_wr(mask_wr),
    .mask_din(mask_din), .mask_clr_edge(mask_clr_edge), .ien_set(ien_set),
    .ien_clr(ien_clr), .accept(accept), .irq_pend(irq_pend),
    .irq_vec(irq_vec), .vec_ext(vec_ext), .ext_ack(ext_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    irq_raw = '0; mask_wr = 0; mask_din = '0; mask_clr_edge = 0;
    ien_set = 0; ien_clr = 0; accept = 0; rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic wr_mask(input logic [2:0] m, input logic clr);
    mask_wr = 1; mask_din = m; mask_clr_edge = clr;
    cyc(1);
    mask_wr = 0; mask_clr_edge = 0;
  endtask

  task automatic pulse_ien(input logic s, input logic c);
    ien_set = s; ien_clr = c;
    cyc(1);
    ien_set = 0; ien_clr = 0;
  endtask

  task automatic pulse_accept();
    accept = 1;
    cyc(1);
    accept = 0;
  endtask

  initial begin
    cyc(20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R7 reset state
    chk("R7 pend after reset", irq_pend, 0);
    chk("R7 vec after reset", irq_vec, 0);
    chk("R7 ext_ack after reset", ext_ack, 0);
    irq_raw = 5'b00100;
    pulse_ien(1, 0);
    cyc(4);
    chk("R7 masks set at reset", irq_pend, 0);
    irq_raw = '0;
    cyc(4);

    // table walk: R1 R2 R3 R5 R6 R9 R10
    for (int k = 0; k < NTBL; k++) begin
      wr_mask(TBL[k][21:19], 0);
      pulse_ien(TBL[k][18], !TBL[k][18]);
      irq_raw = TBL[k][26:22];
      cyc(4);
      chk($sformatf("R2 table %0d pend", k), irq_pend, TBL[k][17]);
      chk($sformatf("R9 table %0d ext", k), vec_ext, TBL[k][16]);
      chk($sformatf("R10 table %0d vec", k), irq_vec, TBL[k][15:0]);
      irq_raw = '0;
      cyc(4);
      wr_mask(TBL[k][21:19], 1);
    end

    // R4 sticky edge latch and software clear
    do_reset();
    wr_mask(3'b000, 0);
    pulse_ien(1, 0);
    irq_raw = 5'b01000;
    cyc(4);
    chk("R4 edge captured", irq_vec, 16'h003C);
    irq_raw = '0;
    cyc(4);
    chk("R4 latch holds after fall", irq_pend, 1);
    wr_mask(3'b000, 0);
    chk("R4 write without clear keeps latch", irq_pend, 1);
    wr_mask(3'b000, 1);
    chk("R4 write with clear empties latch", irq_pend, 0);

    // R4/R5 edge captured while masked, R8 accept empties it
    wr_mask(3'b100, 0);
    irq_raw = 5'b01000;
    cyc(4);
    irq_raw = '0;
    cyc(4);
    chk("R5 masked edge not pending", irq_pend, 0);
    wr_mask(3'b000, 0);
    chk("R4 masked edge remembered", irq_vec, 16'h003C);
    pulse_accept();
    chk("R8 accept drops request", irq_pend, 0);
    pulse_ien(1, 0);
    chk("R8 accept cleared edge latch", irq_pend, 0);

    // R1 level behaviour and latency
    irq_raw = 5'b00100;
    cyc(4);
    chk("R1 level pending", irq_vec, 16'h0034);
    irq_raw = '0;
    cyc(4);
    chk("R1 level released", irq_pend, 0);
    irq_raw = 5'b00010;
    cyc(1);
    chk("R1 not yet after one edge", irq_pend, 0);
    cyc(1);
    chk("R1 pending after two edges", irq_pend, 1);
    irq_raw = '0;
    cyc(4);

    // R3 non-maskable line
    do_reset();
    irq_raw = 5'b10000;
    cyc(4);
    chk("R3 nmi with enable off", irq_vec, 16'h0024);
    irq_raw = '0;
    cyc(4);
    chk("R3 nmi drops when input falls", irq_pend, 0);
    irq_raw = 5'b10000;
    cyc(4);
    pulse_accept();
    chk("R8 nmi taken clears latch", irq_pend, 0);
    cyc(4);
    chk("R3 held high does not re-arm", irq_pend, 0);
    irq_raw = '0;
    cyc(4);

    // R9 general line acknowledge
    do_reset();
    pulse_ien(1, 0);
    irq_raw = 5'b00001;
    cyc(4);
    chk("R9 general ext flag", vec_ext, 1);
    chk("R9 general vec zero", irq_vec, 0);
    accept = 1;
    cyc(1);
    accept = 0;
    chk("R9 ext_ack after accept", ext_ack, 1);
    chk("R8 enable cleared by accept", irq_pend, 0);
    cyc(1);
    chk("R9 ext_ack one cycle", ext_ack, 0);
    pulse_ien(1, 0);
    chk("R6 set restores general", irq_pend, 1);

    // R6 clear wins over set
    pulse_ien(1, 1);
    chk("R6 clear wins", irq_pend, 0);

    // R8 accept with nothing pending does nothing
    irq_raw = '0;
    pulse_ien(1, 0);
    cyc(3);
    chk("R8 idle before accept", irq_pend, 0);
    pulse_accept();
    irq_raw = 5'b00001;
    cyc(4);
    chk("R8 idle accept kept enable", irq_pend, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule